// File: doc/BRIEF.md
# Microcoded Control Sequencer for an Accumulator Machine

This block is the control unit of a small accumulator machine that has four instructions: load, add, store and branch-if-zero. A sixteen-word control store is fixed in logic. Each word holds fifteen datapath control bits, a four-bit successor address and a one-bit flag that merges the accumulator-zero test into that successor. On every clock the sequencer moves to a new microword. It keeps the word's address in a micro-address register and keeps the word itself in a microinstruction register. The registered control bits drive the datapath directly for that cycle.

The datapath supplies two inputs. The first is the two-bit opcode field of the instruction register. A decode word reads it and picks the first microword of that instruction from a four-entry table. The second is a flag that is high when the accumulator holds zero. The branch word reads this flag and ORs it into bit 0 of its successor address. The asynchronous reset is asserted at once and released in step with the clock through a short synchronizer.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and `ctrl` is 0x0220, which is the fetch word's MAR_in and PC_out bits. The reset takes effect without waiting for a clock edge.
- R2: The fetch sequence runs 0, then 2, then 3, then 4. Word 2 drives pc_incr and read (0x0018). Word 3 drives IR_in and MDR_out (0x0880).
- R3: Word 4 drives only the dispatch bit, bit 0 (0x0001). The next address then comes from the opcode: 00 goes to 5, 01 goes to 8, 10 goes to 12 and 11 goes to 15.
- R4: The load path runs 5 (0x0600), then 6 (0x0008), then 7 (0x4080), then returns to 0.
- R5: The add path runs 8 (0x0600), then 9 (0x0008), then 10 (0x3000), then 11 (0x4004), then returns to 0.
- R6: The store path runs 12 (0x0600), then 13 (0x2100), then 14 (0x0002), then returns to 0.
- R7: Word 15 drives no control bits. Its successor is 1 when `acc_zero` is high and 0 when `acc_zero` is low.
- R8: Word 1 drives IR_out and PC_in (0x0440) and is followed by word 0.
- R9: The opcode input has no effect in any word other than 4. The `acc_zero` input has no effect in any word other than 15.
- R10: After `rst_n` rises, `upc` stays at 0 for two clock edges and shows 2 after the third edge.
- R11: The bits of `ctrl`, from bit 14 down to bit 0, are: ACC_in, ACC_out, alu_add, IR_in, IR_out, MAR_in, MDR_in, MDR_out, PC_in, PC_out, pc_incr, read, TMP_out, write and dispatch. Each word's bits are driven for exactly the one cycle in which `upc` holds that word's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 2 | Opcode field of the instruction register |
| acc_zero | input | 1 | High when the accumulator equals zero |
| ctrl | output | 15 | Registered datapath control bits |
| upc | output | 4 | Address of the current microword |

## Verification
The bench uses the default parameters: a four-bit micro-address, a two-bit opcode, a fifteen-bit control field and a two-stage reset synchronizer. With these values one cycle-by-cycle walk can run every instruction path. Both outcomes of the zero branch are exercised. Every one of the sixteen microwords is visited. On the cycles where an input is not supposed to matter, the opcode and zero flag are set to values that would change the path if they were read. The two-stage synchronizer makes the release latency short enough to count edge by edge. The asynchronous reset is also asserted in the middle of an instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 4;
  localparam int OPC_W  = 2;
  localparam int CTRL_W = 15;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] nxt;
    logic              zmerge;
  } uword_t;

  // Fixed microprogram, bit 0 of ctrl is the dispatch request
  function automatic uword_t cs_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      4'h0: begin w.ctrl = 15'h0220; w.nxt = 4'h2; end
      4'h1: begin w.ctrl = 15'h0440; w.nxt = 4'h0; end
      4'h2: begin w.ctrl = 15'h0018; w.nxt = 4'h3; end
      4'h3: begin w.ctrl = 15'h0880; w.nxt = 4'h4; end
      4'h4: begin w.ctrl = 15'h0001; w.nxt = 4'h0; end
      4'h5: begin w.ctrl = 15'h0600; w.nxt = 4'h6; end
      4'h6: begin w.ctrl = 15'h0008; w.nxt = 4'h7; end
      4'h7: begin w.ctrl = 15'h4080; w.nxt = 4'h0; end
      4'h8: begin w.ctrl = 15'h0600; w.nxt = 4'h9; end
      4'h9: begin w.ctrl = 15'h0008; w.nxt = 4'ha; end
      4'ha: begin w.ctrl = 15'h3000; w.nxt = 4'hb; end
      4'hb: begin w.ctrl = 15'h4004; w.nxt = 4'h0; end
      4'hc: begin w.ctrl = 15'h0600; w.nxt = 4'hd; end
      4'hd: begin w.ctrl = 15'h2100; w.nxt = 4'he; end
      4'he: begin w.ctrl = 15'h0002; w.nxt = 4'h0; end
      default: begin w.ctrl = '0; w.nxt = 4'h0; w.zmerge = 1'b1; end
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[g] <= 1'b0;
        else        sr_q[g] <= (g == 0) ? 1'b1 : sr_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  always_comb word = cs_word(addr);
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  uword_t            cur,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              acc_zero,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [ADDR_W-1:0] disp_addr;

  always_comb begin
    case (opcode)
      2'b00:   disp_addr = 4'h5;
      2'b01:   disp_addr = 4'h8;
      2'b10:   disp_addr = 4'hc;
      default: disp_addr = 4'hf;
    endcase
  end

  always_comb begin
    if (cur.ctrl[0])
      nxt_addr = disp_addr;
    else if (cur.zmerge)
      nxt_addr = cur.nxt | {{(ADDR_W-1){1'b0}}, acc_zero};
    else
      nxt_addr = cur.nxt;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              acc_zero,
  output logic [CTRL_W-1:0] ctrl,
  output logic [ADDR_W-1:0] upc
);
  localparam uword_t RESET_WORD = cs_word('0);

  logic              rs_n;
  logic [ADDR_W-1:0] csar_q, csar_d;
  uword_t            csir_q, csir_d;
  logic              adv_en;

  useq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rs_n)
  );

  useq_next_addr u_next (
    .cur(csir_q), .opcode(opcode), .acc_zero(acc_zero), .nxt_addr(csar_d)
  );

  useq_store u_store (.addr(csar_d), .word(csir_d));

  assign adv_en = 1'b1;

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      csar_q <= '0;
      csir_q <= RESET_WORD;
    end else if (adv_en) begin
      csar_q <= csar_d;
      csir_q <= csir_d;
    end
  end

  assign ctrl = csir_q.ctrl;
  assign upc  = csar_q;

  // R2 fetch word is followed by the opcode read word
  p_fetch_r2: assert property (@(posedge clk) disable iff (!rs_n)
    upc == 4'h0 |=> upc == 4'h2);
  // R3 dispatch only lands on an instruction entry point
  p_dispatch_r3: assert property (@(posedge clk) disable iff (!rs_n)
    upc == 4'h4 |=> (upc == 4'h5 || upc == 4'h8 || upc == 4'hc || upc == 4'hf));
  p_disp_bit_r3: assert property (@(posedge clk) disable iff (!rs_n)
    ctrl[0] |-> upc == 4'h4);
  // R7 zero merge outcomes
  p_brz_taken_r7: assert property (@(posedge clk) disable iff (!rs_n)
    (upc == 4'hf && acc_zero) |=> upc == 4'h1);
  p_brz_fall_r7: assert property (@(posedge clk) disable iff (!rs_n)
    (upc == 4'hf && !acc_zero) |=> upc == 4'h0);
  // R8 taken branch word returns to fetch
  p_ret_r8: assert property (@(posedge clk) disable iff (!rs_n)
    upc == 4'h1 |=> upc == 4'h0);
  // R11 bus write and read never requested in one word
  p_rw_excl_r11: assert property (@(posedge clk) disable iff (!rs_n)
    !(ctrl[3] && ctrl[1]));
endmodule

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  opcode;
  logic        acc_zero;
  logic [14:0] ctrl;
  logic [3:0]  upc;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  useq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .acc_zero(acc_zero),
    .ctrl(ctrl), .upc(upc)
  );

  // expected control bits per address, from the requirements
  function automatic logic [14:0] exp_ctrl(input logic [3:0] a);
    case (a)
      4'h0: return 15'h0220;
      4'h1: return 15'h0440;
      4'h2: return 15'h0018;
      4'h3: return 15'h0880;
      4'h4: return 15'h0001;
      4'h5, 4'h8, 4'hc: return 15'h0600;
      4'h6, 4'h9: return 15'h0008;
      4'h7: return 15'h4080;
      4'ha: return 15'h3000;
      4'hb: return 15'h4004;
      4'hd: return 15'h2100;
      4'he: return 15'h0002;
      default: return 15'h0000;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'h0, 4'h2, 4'h3: return "R2 R9";
      4'h4: return "R3";
      4'h5, 4'h6, 4'h7: return "R4 R9";
      4'h8, 4'h9, 4'ha, 4'hb: return "R5 R9";
      4'hc, 4'hd, 4'he: return "R6 R9";
      4'hf: return "R7";
      default: return "R8 R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // {opcode, acc_zero, expected upc}; noise on inputs outside words 4 and 15
  localparam logic [6:0] VEC [33] = '{
    {2'b11,1'b1,4'h2}, {2'b10,1'b0,4'h3}, {2'b00,1'b1,4'h4},
    {2'b11,1'b1,4'h5}, {2'b01,1'b0,4'h6}, {2'b11,1'b1,4'h7}, {2'b10,1'b1,4'h0},
    {2'b00,1'b1,4'h2}, {2'b11,1'b0,4'h3}, {2'b01,1'b0,4'h4},
    {2'b00,1'b1,4'h8}, {2'b11,1'b1,4'h9}, {2'b10,1'b1,4'ha}, {2'b00,1'b1,4'hb},
    {2'b11,1'b0,4'h0},
    {2'b01,1'b1,4'h2}, {2'b00,1'b1,4'h3}, {2'b10,1'b0,4'h4},
    {2'b00,1'b1,4'hc}, {2'b11,1'b1,4'hd}, {2'b01,1'b1,4'he}, {2'b00,1'b1,4'h0},
    {2'b00,1'b0,4'h2}, {2'b01,1'b0,4'h3}, {2'b11,1'b0,4'h4},
    {2'b00,1'b1,4'hf}, {2'b10,1'b0,4'h1}, {2'b01,1'b0,4'h0},
    {2'b10,1'b1,4'h2}, {2'b00,1'b1,4'h3}, {2'b11,1'b1,4'h4},
    {2'b01,1'b0,4'hf}, {2'b00,1'b1,4'h0}
  };

  initial begin
    #(200000*10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; opcode = 2'b11; acc_zero = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {11'd0, upc}, 15'd0);
    chk("R1", ctrl, 15'h0220);
    rst_n = 1'b1;
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd0);
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd0);
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd2);
    for (int i = 0; i < 33; i++) begin
      opcode   = VEC[i][6:5];
      acc_zero = VEC[i][4];
      chk(req_of(VEC[i][3:0]), {11'd0, upc}, {11'd0, VEC[i][3:0]});
      chk("R11", ctrl, exp_ctrl(VEC[i][3:0]));
      @(negedge clk);
    end
    // mid-instruction asynchronous reset, between edges
    opcode = 2'b01;
    repeat (4) @(negedge clk);
    @(posedge clk); #3;
    rst_n = 1'b0;
    #1;
    chk("R1", {11'd0, upc}, 15'd0);
    chk("R1", ctrl, 15'h0220);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd0);
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd0);
    @(negedge clk); chk("R10", {11'd0, upc}, 15'd2);
    @(negedge clk); chk("R2", ctrl, 15'h0880);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule